// File: doc/BRIEF.md
# NAND Die Status Register Logic

This block holds the status logic of a single NAND flash die. An abstract array engine sends it start and completion pulses. The block keeps track of how many array operations are in flight, and this count includes a two-deep pipeline for cache-mode page programming. From that state it builds an 8-bit status byte. The byte carries separate cache-ready and array-ready flags, a fail flag for the current operation, a fail flag for the previous operation, and a rewrite-recommended flag taken from the ECC result of a page read.

The host side sends decoded command bytes with a strobe. A status-read command turns the read-out bus over to the status byte, and a read-mode command gives the bus back to the data register. While status is selected, the bus follows every change of the status state in the same cycle the state changes, so no new request is needed. An active-low ready/busy line follows the cache-ready flag at all times.

Top module: `nand_die_status`

## Requirements
- R1: After synchronous reset, the bus shows `data_in`, `rb_n` is 1, and the status byte reads ready, array-ready, no fail, no previous fail and no rewrite.
- R2: A strobed command 8'h70 selects the status byte on `io_out` from the next cycle on. The bus then follows status changes in the same cycle they occur. Command codes other than 8'h70 and 8'h00 leave the selection unchanged.
- R3: A strobed command 8'h00 returns `io_out` to `data_in` from the next cycle on.
- R4: The status byte is laid out as follows: bit 7 = NOT `wp_active`, bit 6 = cache ready, bit 5 = array ready, bit 3 = rewrite recommended, bit 1 = previous fail, bit 0 = current fail. Bits 4 and 2 are 0.
- R5: `rb_n` always equals status bit 6.
- R6: A non-cache operation (`op_kind` 0 = program, 1 = erase, 2 = page read) is accepted only when no operation is in flight. It clears both ready bits until its `op_done`, and then both return to 1.
- R7: A cache program (`op_kind` 3) is accepted whenever bit 6 is 1, even while the array is busy, and at most two operations can be in flight. `cache_rdy` sets bit 6 only when exactly one cache operation is in flight. `op_done` always sets bit 6. Bit 5 becomes 1 only when nothing is left in flight.
- R8: An accepted cache start copies the current fail bit into the previous-fail bit and clears the current fail bit. An accepted non-cache start clears the current fail bit and keeps the previous-fail bit.
- R9: `op_done` for a program, erase or cache program loads the current fail bit from `op_fail`.
- R10: `op_done` for a page read loads the current fail bit with `ecc_res[1]` (codes 2 and 3 mean uncorrectable) and sets the rewrite bit only for code 1 (corrected). Every accepted start clears the rewrite bit.
- R11: `op_done` with nothing in flight is ignored. An accepted `op_done` blocks an `op_start` in the same cycle. A start that is not accepted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Decoded command byte |
| wp_active | input | 1 | 1 = die write protected |
| op_start | input | 1 | Array operation start pulse |
| op_kind | input | 2 | 0 program, 1 erase, 2 page read, 3 cache program |
| op_done | input | 1 | Oldest in-flight operation completed |
| op_fail | input | 1 | Pass/fail of the completing program or erase |
| cache_rdy | input | 1 | Cache register free to accept new data |
| ecc_res | input | 2 | 0 clean, 1 corrected, 2/3 uncorrectable |
| data_in | input | 8 | Byte from the data register |
| io_out | output | 8 | Read-out bus |
| rb_n | output | 1 | Ready/busy, low = busy |

## Verification
Directed sequences come first. The first walks a single program with a failure, which separates the non-cache ready handling from the cache handling. The second is a two-deep cache pipeline, which shows whether the previous-fail bit shifts at a start or at a completion, and whether `cache_rdy` is honoured only with one operation in flight. The third is two page reads with corrected and then uncorrectable ECC codes, which tells the rewrite flag and the read fail source apart from `op_fail`. After these, seeded random traffic mixes commands, simultaneous start/done/release pulses and write-protect toggles against a reference model. This exposes priority and acceptance errors that the fixed sequences never reach.

// File: rtl/nds_pkg.sv
package nds_pkg;

    localparam int          BUS_W        = 8;
    localparam int          CMD_W        = 8;
    localparam int          MAX_INFLIGHT = 2;
    localparam logic [CMD_W-1:0] CMD_SHOW_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] CMD_SHOW_DATA   = 8'h00;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_READ  = 2'd2,
        OP_CACHE = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ECC_CLEAN  = 2'd0,
        ECC_FIXED  = 2'd1,
        ECC_BAD    = 2'd2,
        ECC_BAD_X  = 2'd3
    } ecc_res_e;

    // bit order is the status byte order, MSB first
    typedef struct packed {
        logic wp_open;
        logic rdy;
        logic ardy;
        logic rsv4;
        logic rewrite;
        logic rsv2;
        logic fail_prev;
        logic fail_now;
    } stat_t;

    typedef struct packed {
        logic rdy;
        logic ardy;
        logic rewrite;
        logic fail_prev;
        logic fail_now;
    } trk_t;

    function automatic stat_t build_status(input logic wp_active, input trk_t t);
        stat_t s;
        s.wp_open   = ~wp_active;
        s.rdy       = t.rdy;
        s.ardy      = t.ardy;
        s.rsv4      = 1'b0;
        s.rewrite   = t.rewrite;
        s.rsv2      = 1'b0;
        s.fail_prev = t.fail_prev;
        s.fail_now  = t.fail_now;
        return s;
    endfunction

    function automatic logic ecc_uncorrectable(input ecc_res_e e);
        return (e == ECC_BAD) || (e == ECC_BAD_X);
    endfunction

endpackage

// File: rtl/nds_op_tracker.sv
module nds_op_tracker
    import nds_pkg::*;
#(
    parameter int INFLIGHT = MAX_INFLIGHT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       op_done,
    input  logic       op_fail,
    input  logic       cache_rdy,
    input  logic [1:0] ecc_res,
    output trk_t       trk
);

    localparam int CNT_W = $clog2(INFLIGHT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INFLIGHT);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    op_kind_e         kind_q;
    trk_t             st_q;

    op_kind_e req_kind;
    ecc_res_e ecc_e;
    logic     done_ev, rel_ev, start_ok, start_ev;

    assign req_kind = op_kind_e'(op_kind);
    assign ecc_e    = ecc_res_e'(ecc_res);

    // completion outranks everything else in a cycle
    assign done_ev  = op_done && (cnt_q != '0);
    assign rel_ev   = !done_ev && cache_rdy && !st_q.rdy
                      && (kind_q == OP_CACHE) && (cnt_q == CNT_ONE);
    assign start_ok = st_q.rdy && ((req_kind == OP_CACHE) ? (cnt_q < CNT_MAX)
                                                          : (cnt_q == '0));
    assign start_ev = !done_ev && !rel_ev && op_start && start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            kind_q       <= OP_PROG;
            st_q.rdy     <= 1'b1;
            st_q.ardy    <= 1'b1;
            st_q.rewrite <= 1'b0;
            st_q.fail_prev <= 1'b0;
            st_q.fail_now  <= 1'b0;
        end else if (done_ev) begin
            cnt_q    <= cnt_q - CNT_ONE;
            st_q.rdy <= 1'b1;
            if (cnt_q == CNT_ONE) st_q.ardy <= 1'b1;
            if (kind_q == OP_READ) begin
                st_q.fail_now <= ecc_uncorrectable(ecc_e);
                st_q.rewrite  <= (ecc_e == ECC_FIXED);
            end else begin
                st_q.fail_now <= op_fail;
            end
        end else if (rel_ev) begin
            st_q.rdy <= 1'b1;
        end else if (start_ev) begin
            cnt_q        <= cnt_q + CNT_ONE;
            kind_q       <= req_kind;
            st_q.rdy     <= 1'b0;
            st_q.ardy    <= 1'b0;
            st_q.rewrite <= 1'b0;
            st_q.fail_now <= 1'b0;
            if (req_kind == OP_CACHE) st_q.fail_prev <= st_q.fail_now;
        end
    end

    assign trk = st_q;

    // R7
    ardy_implies_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ardy |-> st_q.rdy);

    // R11
    inflight_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R8
    cache_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (start_ev && req_kind == OP_CACHE) |=>
            (st_q.fail_prev == $past(st_q.fail_now)) && !st_q.fail_now);

    // R6
    last_done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (done_ev && cnt_q == CNT_ONE) |=> (st_q.rdy && st_q.ardy && cnt_q == '0));

endmodule

// File: rtl/nds_status_pack.sv
module nds_status_pack
    import nds_pkg::*;
(
    input  logic  wp_active,
    input  trk_t  trk,
    output stat_t status
);

    assign status = build_status(wp_active, trk);

endmodule

// File: rtl/nds_out_steer.sv
module nds_out_steer
    import nds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  stat_t            status,
    input  logic [BUS_W-1:0] data_in,
    output logic [BUS_W-1:0] io_out,
    output logic             show_status
);

    logic show_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            show_q <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd_code == CMD_SHOW_STATUS)    show_q <= 1'b1;
            else if (cmd_code == CMD_SHOW_DATA) show_q <= 1'b0;
        end
    end

    // combinational select: status changes appear without a new request
    assign io_out      = show_q ? BUS_W'(status) : data_in;
    assign show_status = show_q;

    // R2
    status_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_SHOW_STATUS) |=> show_q);

    // R3
    data_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_SHOW_DATA) |=> (io_out == data_in));

endmodule

// File: rtl/nand_die_status.sv
module nand_die_status
    import nds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       wp_active,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       op_done,
    input  logic       op_fail,
    input  logic       cache_rdy,
    input  logic [1:0] ecc_res,
    input  logic [7:0] data_in,
    output logic [7:0] io_out,
    output logic       rb_n
);

    trk_t  trk;
    stat_t status;
    logic  show_status;

    nds_op_tracker #(.INFLIGHT(MAX_INFLIGHT)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_done   (op_done),
        .op_fail   (op_fail),
        .cache_rdy (cache_rdy),
        .ecc_res   (ecc_res),
        .trk       (trk)
    );

    nds_status_pack u_pack (
        .wp_active (wp_active),
        .trk       (trk),
        .status    (status)
    );

    nds_out_steer u_steer (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .status      (status),
        .data_in     (data_in),
        .io_out      (io_out),
        .show_status (show_status)
    );

    assign rb_n = status.rdy;

    // R5
    rb_match_chk: assert property (@(posedge clk) disable iff (rst)
        show_status |-> (io_out[6] == rb_n));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        show_status |-> (io_out[4] == 1'b0 && io_out[2] == 1'b0));

    // R4
    wp_bit_chk: assert property (@(posedge clk) disable iff (rst)
        show_status |-> (io_out[7] == !wp_active));

endmodule

// File: tb/nand_die_status_test.sv
module nand_die_status_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       wp_active = 1'b0;
    logic       op_start = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       op_done = 1'b0;
    logic       op_fail = 1'b0;
    logic       cache_rdy = 1'b0;
    logic [1:0] ecc_res = 2'd0;
    logic [7:0] data_in = 8'h5A;
    logic [7:0] io_out;
    logic       rb_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference state
    bit   m_en, m_rdy, m_ardy, m_fail, m_failc, m_rw;
    int   m_cnt;
    logic [1:0] m_kind;

    always #10 clk = ~clk;   // 50 MHz

    nand_die_status uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wp_active(wp_active), .op_start(op_start), .op_kind(op_kind),
        .op_done(op_done), .op_fail(op_fail), .cache_rdy(cache_rdy),
        .ecc_res(ecc_res), .data_in(data_in), .io_out(io_out), .rb_n(rb_n)
    );

    function automatic logic [7:0] exp_status();
        return {~wp_active, m_rdy, m_ardy, 1'b0, m_rw, 1'b0, m_failc, m_fail};
    endfunction

    task automatic model_update();
        if (rst) begin
            m_en = 0; m_rdy = 1; m_ardy = 1; m_cnt = 0; m_kind = 2'd0;
            m_fail = 0; m_failc = 0; m_rw = 0;
        end else begin
            if (cmd_valid) begin
                if (cmd_code == 8'h70) m_en = 1;
                else if (cmd_code == 8'h00) m_en = 0;
            end
            if (op_done && m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                m_rdy = 1;
                if (m_cnt == 0) m_ardy = 1;
                if (m_kind == 2'd2) begin
                    m_fail = ecc_res[1];
                    m_rw   = (ecc_res == 2'd1);
                end else begin
                    m_fail = op_fail;
                end
            end else if (cache_rdy && !m_rdy && m_kind == 2'd3 && m_cnt == 1) begin
                m_rdy = 1;
            end else if (op_start && m_rdy &&
                         ((op_kind == 2'd3) ? (m_cnt < 2) : (m_cnt == 0))) begin
                m_cnt = m_cnt + 1;
                m_kind = op_kind;
                m_rdy = 0; m_ardy = 0; m_rw = 0;
                if (op_kind == 2'd3) m_failc = m_fail;
                m_fail = 0;
            end
        end
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        check8({7'd0, rb_n}, {7'd0, m_rdy}, "R5 rb_n");
        if (m_en) check8(io_out, exp_status(), "R4 status byte");
        else      check8(io_out, data_in, "R3 data path");
    endtask

    task automatic clear_pulses();
        cmd_valid = 0; op_start = 0; op_done = 0; cache_rdy = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_model();
        clear_pulses();
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_valid = 1; cmd_code = c; tick();
    endtask

    task automatic start(input logic [1:0] k);
        op_start = 1; op_kind = k; tick();
    endtask

    task automatic done(input logic f, input logic [1:0] e);
        op_done = 1; op_fail = f; ecc_res = e; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        // R1
        check8(io_out, 8'h5A, "R1 reset selects data");
        check8({7'd0, rb_n}, 8'd1, "R1 reset ready");
        cmd(8'h70);
        check8(io_out, 8'hE0, "R1 R2 status after reset");
        cmd(8'h55);
        check8(io_out, 8'hE0, "R2 other code keeps status");
        start(2'd0);
        check8(io_out, 8'h80, "R6 program busy");
        check8({7'd0, rb_n}, 8'd0, "R5 busy low");
        start(2'd2);
        check8(io_out, 8'h80, "R11 start while busy ignored");
        done(1'b1, 2'd0);
        check8(io_out, 8'hE1, "R9 program fail");
        start(2'd3);
        check8(io_out, 8'h82, "R8 cache start shifts fail");
        cache_rdy = 1; tick();
        check8(io_out, 8'hC2, "R7 cache released");
        start(2'd3);
        check8(io_out, 8'h80, "R8 second cache start");
        cache_rdy = 1; tick();
        check8(io_out, 8'h80, "R7 release ignored with two in flight");
        done(1'b1, 2'd0);
        check8(io_out, 8'hC1, "R7 one left in array");
        op_start = 1; op_kind = 2'd0;
        done(1'b0, 2'd0);
        check8(io_out, 8'hE0, "R11 done beats start");
        start(2'd2);
        done(1'b1, 2'd1);
        check8(io_out, 8'hE8, "R10 corrected read");
        start(2'd2);
        check8(io_out, 8'h80, "R10 start clears rewrite");
        done(1'b0, 2'd2);
        check8(io_out, 8'hE1, "R10 uncorrectable read");
        done(1'b0, 2'd0);
        check8(io_out, 8'hE1, "R11 done with nothing in flight");
        wp_active = 1; #1;
        check8(io_out, 8'h61, "R4 write protect bit");
        wp_active = 0;
        data_in = 8'hC3;
        cmd(8'h00);
        check8(io_out, 8'hC3, "R3 back to data");

        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            cmd_valid = (r < 2);
            cmd_code  = (r == 0) ? 8'h70 : ($urandom_range(0, 1) ? 8'h00 : 8'($urandom));
            op_start  = ($urandom_range(0, 4) == 0);
            op_kind   = 2'($urandom_range(0, 3));
            op_done   = ($urandom_range(0, 5) == 0);
            op_fail   = 1'($urandom);
            cache_rdy = ($urandom_range(0, 4) == 0);
            ecc_res   = 2'($urandom);
            data_in   = 8'($urandom);
            if ($urandom_range(0, 31) == 0) wp_active = ~wp_active;
            tick();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule